// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects interrupt requests from peripherals, which are organised in numbered groups, and picks the one the processor should take next. Each maskable group has its own control word with a priority level, an enable bit, a request latch and a read-only detect bit. A reserved group 0 gathers three non-maskable sources: an external pin, a watchdog overflow and a system error. Group 0 ignores both the processor's global enable flag and its mask level.

The processor supplies its global enable flag and its 3-bit mask level as inputs. The controller raises a request with the winning group and level whenever the winner is acceptable. When the processor acknowledges, the controller reports the accepted group and level for one cycle. In the same cycle it pulses a signal that tells the processor to clear its global enable. Request latches are cleared only by software, through a simple register bus that has per-byte write enables.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset every control word reads 0, `irq_req` is 0 and `acc_valid`/`ie_clear` are 0.
- R2: Group n's control word is at byte address 0x100 + 4·n (n = 0, 2..19). For maskable groups the layout is: bit 0 = enable, bit 1 = request, bit 2 = detect (read-only), bits 10:8 = level. All other bits read 0.
- R3: Byte enable bit 0 writes bits 7:0 (enable, request clear). Byte enable bit 1 writes bits 15:8 (level). A lane whose enable is 0 leaves its fields unchanged.
- R4: A one-cycle high on `periph_req[n]` sets group n's request latch. Writing 0 to the request bit clears it. Writing 1 to the request bit has no effect.
- R5: The detect bit reads as request AND enable.
- R6: A maskable group is accepted only when its level is strictly below `cpu_im`. With `cpu_im` = 000, no maskable group is accepted.
- R7: With `cpu_ie` = 0, no maskable group raises `irq_req`.
- R8: Among groups that are pending and enabled, the numerically lowest level wins. On a tie in level, the lowest group number wins.
- R9: Group 0 bits 2:0 latch the pin, watchdog and system-error sources in that order, and each is cleared by writing 0 to it. Any set bit raises `irq_req` with `irq_nmi` = 1, group 0 and level 0, whatever the state of `cpu_ie` and `cpu_im`. It takes precedence over every maskable group.
- R10: If `cpu_ack` is high while `irq_req` is high at a clock edge, then in the next cycle only, `acc_valid` and `ie_clear` are 1 and `acc_group`/`acc_level` hold the group and level reported at that edge.
- R11: An acknowledge does not clear the request latch.
- R12: The unused group 1 slot and addresses outside the map read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from address) |
| periph_req | input | 20 | Per-group request pulses (bits 0 and 1 unused) |
| nmi_src | input | 3 | Non-maskable source pulses: pin, watchdog, system error |
| cpu_ie | input | 1 | Processor global enable flag |
| cpu_im | input | 3 | Processor mask level |
| cpu_ack | input | 1 | Processor acknowledge |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_nmi | output | 1 | Current request is non-maskable |
| irq_group | output | 5 | Group of the current request |
| irq_level | output | 3 | Level of the current request |
| acc_valid | output | 1 | Acceptance pulse |
| acc_group | output | 5 | Accepted group |
| acc_level | output | 3 | Accepted level |
| ie_clear | output | 1 | Pulse telling the processor to clear its enable flag |

## Verification
The assertions check on every cycle that a pending non-maskable source always wins as group 0 and that a maskable request never appears with a zero mask, a cleared enable flag or a level at or above the mask. They also check that every acknowledged request produces exactly one acceptance pulse carrying the group seen at the acknowledge edge. Only the bench scenarios can show the register layout, the byte-lane behaviour, the write-one-has-no-effect rule for request bits, tie-breaking by group number, and that latches survive an acknowledge.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  localparam int LVL_W   = 3;
  localparam int DATA_W  = 16;
  localparam int NMI_SRC = 3;
  localparam int EN_BIT  = 0;
  localparam int RQ_BIT  = 1;
  localparam int DT_BIT  = 2;
  localparam int LV_LSB  = 8;

  // maskable acceptance: level strictly below mask, mask 0 blocks all
  function automatic logic lvl_ok(input logic [LVL_W-1:0] lvl,
                                  input logic [LVL_W-1:0] im);
    return (im != '0) && (lvl < im);
  endfunction

  // candidate replaces current best when no best yet or level not worse
  function automatic logic takes_over(input logic have_best,
                                      input logic [LVL_W-1:0] cand,
                                      input logic [LVL_W-1:0] best);
    return !have_best || (cand <= best);
  endfunction
endpackage

// File: rtl/gpic_grp_reg.sv
module gpic_grp_reg
  import gpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [1:0]        be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              req_pulse,
  output logic [DATA_W-1:0] rdata,
  output logic              pend,
  output logic [LVL_W-1:0]  level
);
  logic en_q, req_q;
  logic [LVL_W-1:0] lvl_q;
  logic wr_lo, wr_hi;

  assign wr_lo = sel && we && be[0];
  assign wr_hi = sel && we && be[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (wr_lo) begin
        en_q <= wdata[EN_BIT];
        if (!wdata[RQ_BIT]) req_q <= 1'b0;
      end
      if (wr_hi) lvl_q <= wdata[LV_LSB +: LVL_W];
      if (req_pulse) req_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[EN_BIT] = en_q;
    rdata[RQ_BIT] = req_q;
    rdata[DT_BIT] = en_q & req_q;
    rdata[LV_LSB +: LVL_W] = lvl_q;
  end

  assign pend  = en_q & req_q;
  assign level = lvl_q;
endmodule

// File: rtl/gpic_nmi_reg.sv
module gpic_nmi_reg
  import gpic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               we,
  input  logic [1:0]         be,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NMI_SRC-1:0] src_pulse,
  output logic [DATA_W-1:0]  rdata,
  output logic               pend
);
  logic [NMI_SRC-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      for (int i = 0; i < NMI_SRC; i++) begin
        if (sel && we && be[0] && !wdata[i]) req_q[i] <= 1'b0;
        if (src_pulse[i]) req_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[NMI_SRC-1:0] = req_q;
  end

  assign pend = |req_q;
endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
  import gpic_pkg::*;
#(
  parameter int NUM_GRP = 20,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic [NUM_GRP-1:0]       pend,
  input  logic [NUM_GRP*LVL_W-1:0] lvl_flat,
  output logic                     any,
  output logic [GRP_W-1:0]         win_grp,
  output logic [LVL_W-1:0]         win_lvl
);
  always_comb begin
    any     = 1'b0;
    win_grp = '0;
    win_lvl = '0;
    // scan downward so a tie is resolved toward the lowest group
    for (int i = NUM_GRP - 1; i >= 0; i--) begin
      if (pend[i] && takes_over(any, lvl_flat[i*LVL_W +: LVL_W], win_lvl)) begin
        any     = 1'b1;
        win_grp = GRP_W'(i);
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/gpic_accept.sv
module gpic_accept
  import gpic_pkg::*;
#(
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pend,
  input  logic             mk_any,
  input  logic [GRP_W-1:0] mk_grp,
  input  logic [LVL_W-1:0] mk_lvl,
  input  logic             cpu_ie,
  input  logic [LVL_W-1:0] cpu_im,
  input  logic             cpu_ack,
  output logic             irq_req,
  output logic             irq_nmi,
  output logic [GRP_W-1:0] irq_group,
  output logic [LVL_W-1:0] irq_level,
  output logic             acc_valid,
  output logic [GRP_W-1:0] acc_group,
  output logic [LVL_W-1:0] acc_level,
  output logic             ie_clear
);
  logic mk_ok, take;

  assign mk_ok = cpu_ie && mk_any && lvl_ok(mk_lvl, cpu_im);

  always_comb begin
    irq_req   = nmi_pend | mk_ok;
    irq_nmi   = nmi_pend;
    irq_group = nmi_pend ? '0 : (mk_ok ? mk_grp : '0);
    irq_level = nmi_pend ? '0 : (mk_ok ? mk_lvl : '0);
  end

  assign take = cpu_ack && irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      ie_clear  <= 1'b0;
      acc_group <= '0;
      acc_level <= '0;
    end else begin
      acc_valid <= take;
      ie_clear  <= take;
      if (take) begin
        acc_group <= irq_group;
        acc_level <= irq_level;
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gpic_pkg::*;
#(
  parameter int NUM_GRP   = 20,
  parameter int ADDR_W    = 9,
  parameter int BASE_ADDR = 'h100,
  localparam int GRP_W    = $clog2(NUM_GRP),
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [1:0]         bus_be,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_GRP-1:0] periph_req,
  input  logic [NMI_SRC-1:0] nmi_src,
  input  logic               cpu_ie,
  input  logic [LVL_W-1:0]   cpu_im,
  input  logic               cpu_ack,
  output logic               irq_req,
  output logic               irq_nmi,
  output logic [GRP_W-1:0]   irq_group,
  output logic [LVL_W-1:0]   irq_level,
  output logic               acc_valid,
  output logic [GRP_W-1:0]   acc_group,
  output logic [LVL_W-1:0]   acc_level,
  output logic               ie_clear
);
  logic [ADDR_W-1:0]        offs;
  logic [IDX_W-1:0]         idx;
  logic                     in_map;
  logic [DATA_W-1:0]        grp_rd [NUM_GRP];
  logic [NUM_GRP-1:0]       grp_pend;
  logic [NUM_GRP*LVL_W-1:0] grp_lvl;
  logic                     nmi_pend;
  logic                     mk_any;
  logic [GRP_W-1:0]         mk_grp;
  logic [LVL_W-1:0]         mk_lvl;

  assign offs   = bus_addr - ADDR_W'(BASE_ADDR);
  assign idx    = offs[ADDR_W-1:2];
  assign in_map = (bus_addr >= ADDR_W'(BASE_ADDR)) && (idx < IDX_W'(NUM_GRP));

  gpic_nmi_reg u_nmi (
    .clk(clk), .rst_n(rst_n),
    .sel(in_map && idx == '0), .we(bus_we), .be(bus_be), .wdata(bus_wdata),
    .src_pulse(nmi_src), .rdata(grp_rd[0]), .pend(nmi_pend)
  );

  assign grp_rd[1]            = '0;
  assign grp_pend[1:0]        = '0;
  assign grp_lvl[2*LVL_W-1:0] = '0;

  generate
    for (genvar g = 2; g < NUM_GRP; g++) begin : g_grp
      gpic_grp_reg u_reg (
        .clk(clk), .rst_n(rst_n),
        .sel(in_map && idx == IDX_W'(g)), .we(bus_we), .be(bus_be),
        .wdata(bus_wdata), .req_pulse(periph_req[g]),
        .rdata(grp_rd[g]), .pend(grp_pend[g]),
        .level(grp_lvl[g*LVL_W +: LVL_W])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_GRP; i++)
      if (in_map && idx == IDX_W'(i)) bus_rdata = grp_rd[i];
  end

  gpic_arbiter #(.NUM_GRP(NUM_GRP)) u_arb (
    .pend(grp_pend), .lvl_flat(grp_lvl),
    .any(mk_any), .win_grp(mk_grp), .win_lvl(mk_lvl)
  );

  gpic_accept #(.GRP_W(GRP_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .nmi_pend(nmi_pend), .mk_any(mk_any), .mk_grp(mk_grp), .mk_lvl(mk_lvl),
    .cpu_ie(cpu_ie), .cpu_im(cpu_im), .cpu_ack(cpu_ack),
    .irq_req(irq_req), .irq_nmi(irq_nmi), .irq_group(irq_group),
    .irq_level(irq_level), .acc_valid(acc_valid), .acc_group(acc_group),
    .acc_level(acc_level), .ie_clear(ie_clear)
  );
endmodule

// File: rtl/gpic_checker.sv
module gpic_checker #(
  parameter int GRP_W = 5,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_pend,
  input logic             mk_any,
  input logic             cpu_ie,
  input logic [LVL_W-1:0] cpu_im,
  input logic             cpu_ack,
  input logic             irq_req,
  input logic             irq_nmi,
  input logic [GRP_W-1:0] irq_group,
  input logic [LVL_W-1:0] irq_level,
  input logic             acc_valid,
  input logic [GRP_W-1:0] acc_group,
  input logic             ie_clear
);
  a_r9_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (irq_req && irq_nmi && irq_group == '0));

  a_r6_mask_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_im == '0 && !nmi_pend) |-> !irq_req);

  a_r7_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ie && !nmi_pend) |-> !irq_req);

  a_r6_level_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_nmi) |-> (irq_level < cpu_im && mk_any));

  a_r10_take_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req) |=> (acc_valid && ie_clear && acc_group == $past(irq_group)));

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(cpu_ack && irq_req));
endmodule

bind grp_irq_ctrl gpic_checker #(.GRP_W(GRP_W), .LVL_W(gpic_pkg::LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_pend(nmi_pend), .mk_any(mk_any),
  .cpu_ie(cpu_ie), .cpu_im(cpu_im), .cpu_ack(cpu_ack),
  .irq_req(irq_req), .irq_nmi(irq_nmi), .irq_group(irq_group),
  .irq_level(irq_level), .acc_valid(acc_valid), .acc_group(acc_group),
  .ie_clear(ie_clear)
);

// File: tb/grp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module grp_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [19:0] periph_req = '0;
  logic [2:0]  nmi_src = '0;
  logic        cpu_ie = 1'b0;
  logic [2:0]  cpu_im = '0;
  logic        cpu_ack = 1'b0;
  logic        irq_req, irq_nmi, acc_valid, ie_clear;
  logic [4:0]  irq_group, acc_group;
  logic [2:0]  irq_level, acc_level;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  grp_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_req(periph_req), .nmi_src(nmi_src), .cpu_ie(cpu_ie),
    .cpu_im(cpu_im), .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_nmi(irq_nmi),
    .irq_group(irq_group), .irq_level(irq_level), .acc_valid(acc_valid),
    .acc_group(acc_group), .acc_level(acc_level), .ie_clear(ie_clear)
  );

  // {ie, im[2:0], exp_irq, exp_grp[4:0], exp_lvl[2:0]}
  // pending: g5 L3, g7 L3, g12 L6 enabled; g9 L1 disabled
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 3'd7, 1'b0, 5'd0, 3'd0},
    {1'b1, 3'd0, 1'b0, 5'd0, 3'd0},
    {1'b1, 3'd3, 1'b0, 5'd0, 3'd0},
    {1'b1, 3'd4, 1'b1, 5'd5, 3'd3},
    {1'b1, 3'd7, 1'b1, 5'd5, 3'd3},
    {1'b0, 3'd4, 1'b0, 5'd0, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_req(input int g);
    @(negedge clk);
    periph_req[g] = 1'b1;
    @(negedge clk);
    periph_req = '0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired before the bench finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(9'h114, d);
    chk("R1 group5 word after reset", d, 16'h0000);
    chk("R1 irq_req after reset", irq_req, 1'b0);
    chk("R1 acc_valid after reset", acc_valid, 1'b0);
    rst_n = 1'b1;

    // program groups: g5 L3 en, g7 L3 en, g9 L1 dis, g12 L6 en
    wr(9'h114, 2'b11, 16'h0301);
    wr(9'h11C, 2'b11, 16'h0301);
    wr(9'h124, 2'b11, 16'h0100);
    wr(9'h130, 2'b11, 16'h0601);
    pulse_req(5); pulse_req(7); pulse_req(9); pulse_req(12);

    rd(9'h114, d);
    chk("R2 R5 group5 layout with detect", d, 16'h0307);
    rd(9'h124, d);
    chk("R5 group9 detect low when disabled", d, 16'h0102);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cpu_ie = VEC[i][12];
      cpu_im = VEC[i][11:9];
      #1;
      chk($sformatf("R6 R7 R8 vec%0d irq_req", i), irq_req, VEC[i][8]);
      chk($sformatf("R8 vec%0d group", i), irq_group, VEC[i][7:3]);
      chk($sformatf("R8 vec%0d level", i), irq_level, VEC[i][2:0]);
    end

    // clear g5 request through lane 0, level must stay
    wr(9'h114, 2'b01, 16'h0001);
    rd(9'h114, d);
    chk("R4 write 0 clears request", d, 16'h0301);
    cpu_ie = 1'b1; cpu_im = 3'd7;
    #1;
    chk("R8 tie moves to group7", irq_group, 5'd7);

    // lane 1 only: change g7 level to 1
    wr(9'h11C, 2'b10, 16'h0100);
    rd(9'h11C, d);
    chk("R3 high lane write keeps low lane", d, 16'h0107);
    wr(9'h11C, 2'b01, 16'h0703);
    rd(9'h11C, d);
    chk("R3 low lane write keeps level", d, 16'h0107);

    @(negedge clk);
    cpu_im = 3'd2;
    #1;
    chk("R6 level1 under mask2 group", irq_group, 5'd7);
    chk("R6 level1 under mask2 level", irq_level, 3'd1);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    chk("R10 acc_valid after ack", acc_valid, 1'b1);
    chk("R10 ie_clear after ack", ie_clear, 1'b1);
    chk("R10 acc_group", acc_group, 5'd7);
    chk("R10 acc_level", acc_level, 3'd1);
    @(negedge clk);
    chk("R10 acc_valid one cycle", acc_valid, 1'b0);
    chk("R10 ie_clear one cycle", ie_clear, 1'b0);
    rd(9'h11C, d);
    chk("R11 request kept after ack", d, 16'h0107);

    // write 1 to request bit has no effect
    wr(9'h124, 2'b01, 16'h0000);
    wr(9'h124, 2'b01, 16'h0002);
    rd(9'h124, d);
    chk("R4 write 1 does not set request", d, 16'h0100);

    // non-maskable: bypasses ie and mask, beats group7
    @(negedge clk);
    cpu_ie = 1'b0; cpu_im = 3'd0;
    nmi_src = 3'b010;
    @(negedge clk);
    nmi_src = '0;
    #1;
    chk("R9 nmi irq_req", irq_req, 1'b1);
    chk("R9 nmi flag", irq_nmi, 1'b1);
    chk("R9 nmi group", irq_group, 5'd0);
    rd(9'h100, d);
    chk("R9 watchdog bit position", d, 16'h0002);
    cpu_ie = 1'b1; cpu_im = 3'd7;
    #1;
    chk("R9 nmi precedence over group7", irq_group, 5'd0);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    chk("R10 nmi acc_group", acc_group, 5'd0);
    chk("R10 nmi ie_clear", ie_clear, 1'b1);
    wr(9'h100, 2'b01, 16'h0000);
    rd(9'h100, d);
    chk("R9 nmi clear by write 0", d, 16'h0000);
    #1;
    chk("R9 back to group7 after nmi cleared", irq_group, 5'd7);

    // unmapped addresses
    wr(9'h104, 2'b11, 16'hFFFF);
    rd(9'h104, d);
    chk("R12 group1 slot reads 0", d, 16'h0000);
    rd(9'h150, d);
    chk("R12 past end reads 0", d, 16'h0000);
    rd(9'h0FC, d);
    chk("R12 below base reads 0", d, 16'h0000);

    summary();
    $finish;
  end
endmodule